// File: doc/BRIEF.md
# Compressed Instruction Class Decoder

This block classifies one 16-bit compressed instruction halfword and pulls out its operand fields. The result is a 5-bit class code plus a destination index, two source or base indices, an opcode sub-field, a register list and a 32-bit immediate. The immediate is already zero- or sign-extended and already scaled for its class. Several bit patterns overlap, so classification uses a fixed first-match order: a narrower pattern is always tested ahead of the wider pattern that would also accept it. A halfword that fits no pattern raises an undefined flag.

The block sits in front of an execute stage and does not read registers, touch memory or steer the pipeline. A valid strobe travels with each halfword. By default the result is captured in an output register, which gives one cycle of latency. Setting the parameter `REG_OUT` to 0 turns the block into a purely combinational decoder.

Top module: `cinsn_class_dec`

## Requirements
- R1: A halfword that matches no class gives undef_o=1, cls_o=0, and zero on every field output. Unmatched halfwords include 1110 1xxx..., 1011 0001..., 1011 x00x... other than 1011 0000..., and 1011 x01x... or 1011 x11x....
- R2: Halfwords with bits 15:11 = 00011 decode as register add/sub (class 1, bit 10 = 0) or immediate add/sub (class 2, bit 10 = 1), never as shift. In both, op=bit 9, ra=bits 5:3 and rd=bits 2:0. Class 1 takes rb=bits 8:6; class 2 takes imm=bits 8:6 zero-extended.
- R3: Bits 15:7 = 010001110 decode as branch-exchange (class 6), never as high-register ALU. Here rb=bits 6:3 and every other field is zero.
- R4: Bits 15:8 = 11011111 decode as software trap (class 18), never as conditional branch. Here imm=bits 7:0 zero-extended.
- R5: High-register ALU (class 7, bits 15:10 = 010001, not R3) sets op=bits 9:8, rd={bit 7, bits 2:0} and rb=bits 6:3.
- R6: Shift-by-immediate (class 3, bits 15:13 = 000, not R2) sets op=bits 12:11, ra=bits 5:3 and rd=bits 2:0. imm is the amount in bits 10:6, except that an amount of zero with op 1 or 2 gives 32. With op 0, a zero amount stays 0.
- R7: Conditional branch (class 19, bits 15:12 = 1101) sets op=bits 11:8 and imm=sign-extended bits 7:0 times 2. Short branch (class 20, bits 15:11 = 11100) sets imm=sign-extended bits 10:0 times 2.
- R8: Long-branch prefix (class 21, bits 15:11 = 11110) sets imm=sign-extended bits 10:0 shifted left by 12. The suffix (class 22, bits 15:11 = 11111) sets imm=zero-extended bits 10:0 times 2.
- R9: Stack adjust (class 15, bits 15:8 = 10110000) sets op=bit 7 and imm=bits 6:0 times 4. Push/pop (class 16, bits 15:12 = 1011, bits 10:9 = 10) sets op[0]=bit 11 (1 = pop), op[1]=bit 8 (extra link/PC slot) and rlist=bits 7:0.
- R10: Immediate memory and address forms set op=bit 11, rd=bits 10:8 (classes 8, 13, 14) or rd=bits 2:0 with ra=bits 5:3 (classes 10, 11, 12). Their immediates are scaled as follows. Literal load (class 8, 01001) uses bits 7:0 times 4. Word (class 10, 0110) uses bits 10:6 times 4. Byte (class 11, 0111) uses bits 10:6 times 1. Half (class 12, 1000) uses bits 10:6 times 2. Stack-relative (class 13, 1001) uses bits 7:0 times 4. Address generation (class 14, 1010) uses bits 7:0 times 4.
- R11: Register-offset memory (class 9, 0101) sets op=bits 11:9, rb=bits 8:6, ra=bits 5:3 and rd=bits 2:0.
- R12: With the output register, valid_o and all fields follow valid_i and insn_i one clock later. Reset clears valid_o and every output.
- R13: The remaining classes are as follows. 8-bit immediate (class 4, 001) sets op=bits 12:11, rd=bits 10:8 and imm=bits 7:0. Two-register ALU (class 5, 010000) sets op=bits 9:6, rb=bits 5:3 and rd=bits 2:0. Block transfer (class 17, 1100) sets op=bit 11, ra=bits 10:8 and rlist=bits 7:0. Any field a class does not define is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Halfword on insn_i is to be decoded |
| insn_i | input | 16 | Instruction halfword |
| valid_o | output | 1 | Decode result is valid |
| undef_o | output | 1 | No class matched |
| cls_o | output | 5 | Class code |
| rd_o | output | 4 | Destination register index |
| ra_o | output | 4 | First source / base register index |
| rb_o | output | 4 | Second source / offset register index |
| op_o | output | 4 | Opcode sub-field |
| rlist_o | output | 8 | Register list |
| imm_o | output | 32 | Extended and scaled immediate |

## Verification
Every one of the 65536 halfwords is decoded and compared against an independent priority-ordered model. If the priority order were wrong, add/sub would show up as a shift, branch-exchange would become a high-register op with op 3, or the 0xDF prefix would turn into a conditional branch. Directed halfwords also exercise the zero shift amount, which a wrong decoder would report as 0 instead of 32 for LSR/ASR. They cover negative displacements that would come out zero-extended, the high-bit destination merge that would drop bit 7, and the gaps in the 1011 group that a decoder with a loose mask would accept. Gaps in the valid strobe check that results appear exactly one cycle later and never appear without a matching input.

// File: rtl/cid_pkg.sv
`timescale 1ns/1ps
package cid_pkg;
    localparam int IW  = 16;  // halfword width
    localparam int XW  = 32;  // extended immediate width
    localparam int CW  = 5;   // class code width
    localparam int RW  = 4;   // register index width
    localparam int OPW = 4;   // opcode sub-field width
    localparam int LW  = 8;   // register list width

    typedef enum logic [CW-1:0] {
        CLS_UNDEF      = 5'd0,
        CLS_ADDSUB_REG = 5'd1,
        CLS_ADDSUB_IMM = 5'd2,
        CLS_SHIFT_IMM  = 5'd3,
        CLS_IMM8       = 5'd4,
        CLS_ALU        = 5'd5,
        CLS_BX         = 5'd6,
        CLS_ALU_HI     = 5'd7,
        CLS_LIT_LOAD   = 5'd8,
        CLS_MEM_REG    = 5'd9,
        CLS_MEM_WORD   = 5'd10,
        CLS_MEM_BYTE   = 5'd11,
        CLS_MEM_HALF   = 5'd12,
        CLS_MEM_SP     = 5'd13,
        CLS_ADDR_GEN   = 5'd14,
        CLS_SP_ADJ     = 5'd15,
        CLS_PUSH_POP   = 5'd16,
        CLS_BLOCK      = 5'd17,
        CLS_TRAP       = 5'd18,
        CLS_BCOND      = 5'd19,
        CLS_BSHORT     = 5'd20,
        CLS_BL_HI      = 5'd21,
        CLS_BL_LO      = 5'd22
    } cls_e;

    typedef struct packed {
        logic           undef;
        cls_e           cls;
        logic [RW-1:0]  rd;
        logic [RW-1:0]  ra;
        logic [RW-1:0]  rb;
        logic [OPW-1:0] op;
        logic [LW-1:0]  rlist;
        logic [XW-1:0]  imm;
    } dec_t;

    function automatic logic [XW-1:0] zext11(input logic [10:0] v);
        return {{(XW-11){1'b0}}, v};
    endfunction

    function automatic logic [XW-1:0] sext8(input logic [7:0] v);
        return {{(XW-8){v[7]}}, v};
    endfunction

    function automatic logic [XW-1:0] sext11(input logic [10:0] v);
        return {{(XW-11){v[10]}}, v};
    endfunction
endpackage

// File: rtl/cid_match.sv
`timescale 1ns/1ps
// Ordered first-match classifier: narrower patterns sit ahead of wider ones.
module cid_match
    import cid_pkg::*;
(
    input  logic [IW-1:0] insn,
    output cls_e          cls
);
    function automatic logic hit(input logic [IW-1:0] h, input logic [IW-1:0] m,
                                 input logic [IW-1:0] p);
        return (h & m) == p;
    endfunction

    always_comb begin
        if      (hit(insn, 16'hFC00, 16'h1800)) cls = CLS_ADDSUB_REG;
        else if (hit(insn, 16'hFC00, 16'h1C00)) cls = CLS_ADDSUB_IMM;
        else if (hit(insn, 16'hE000, 16'h0000)) cls = CLS_SHIFT_IMM;
        else if (hit(insn, 16'hE000, 16'h2000)) cls = CLS_IMM8;
        else if (hit(insn, 16'hFC00, 16'h4000)) cls = CLS_ALU;
        else if (hit(insn, 16'hFF80, 16'h4700)) cls = CLS_BX;
        else if (hit(insn, 16'hFC00, 16'h4400)) cls = CLS_ALU_HI;
        else if (hit(insn, 16'hF800, 16'h4800)) cls = CLS_LIT_LOAD;
        else if (hit(insn, 16'hF000, 16'h5000)) cls = CLS_MEM_REG;
        else if (hit(insn, 16'hF000, 16'h6000)) cls = CLS_MEM_WORD;
        else if (hit(insn, 16'hF000, 16'h7000)) cls = CLS_MEM_BYTE;
        else if (hit(insn, 16'hF000, 16'h8000)) cls = CLS_MEM_HALF;
        else if (hit(insn, 16'hF000, 16'h9000)) cls = CLS_MEM_SP;
        else if (hit(insn, 16'hF000, 16'hA000)) cls = CLS_ADDR_GEN;
        else if (hit(insn, 16'hFF00, 16'hB000)) cls = CLS_SP_ADJ;
        else if (hit(insn, 16'hF600, 16'hB400)) cls = CLS_PUSH_POP;
        else if (hit(insn, 16'hF000, 16'hC000)) cls = CLS_BLOCK;
        else if (hit(insn, 16'hFF00, 16'hDF00)) cls = CLS_TRAP;
        else if (hit(insn, 16'hF000, 16'hD000)) cls = CLS_BCOND;
        else if (hit(insn, 16'hF800, 16'hE000)) cls = CLS_BSHORT;
        else if (hit(insn, 16'hF800, 16'hF000)) cls = CLS_BL_HI;
        else if (hit(insn, 16'hF800, 16'hF800)) cls = CLS_BL_LO;
        else                                    cls = CLS_UNDEF;
    end
endmodule

// File: rtl/cid_fields.sv
`timescale 1ns/1ps
// Per-class field extraction; fields a class does not define stay zero.
module cid_fields
    import cid_pkg::*;
(
    input  logic [IW-1:0] insn,
    input  cls_e          cls,
    output dec_t          dec
);
    logic [4:0] amt5;
    assign amt5 = insn[10:6];

    always_comb begin
        dec       = '0;
        dec.cls   = cls;
        dec.undef = (cls == CLS_UNDEF);
        case (cls)
            CLS_ADDSUB_REG: begin
                dec.op = {3'b0, insn[9]};
                dec.rb = {1'b0, insn[8:6]};
                dec.ra = {1'b0, insn[5:3]};
                dec.rd = {1'b0, insn[2:0]};
            end
            CLS_ADDSUB_IMM: begin
                dec.op  = {3'b0, insn[9]};
                dec.imm = zext11(11'(insn[8:6]));
                dec.ra  = {1'b0, insn[5:3]};
                dec.rd  = {1'b0, insn[2:0]};
            end
            CLS_SHIFT_IMM: begin
                dec.op = {2'b0, insn[12:11]};
                dec.ra = {1'b0, insn[5:3]};
                dec.rd = {1'b0, insn[2:0]};
                if (amt5 == 5'd0 && insn[12:11] != 2'b00)
                    dec.imm = XW'(32);
                else
                    dec.imm = zext11(11'(amt5));
            end
            CLS_IMM8: begin
                dec.op  = {2'b0, insn[12:11]};
                dec.rd  = {1'b0, insn[10:8]};
                dec.imm = zext11(11'(insn[7:0]));
            end
            CLS_ALU: begin
                dec.op = insn[9:6];
                dec.rb = {1'b0, insn[5:3]};
                dec.rd = {1'b0, insn[2:0]};
            end
            CLS_BX: begin
                dec.rb = insn[6:3];
            end
            CLS_ALU_HI: begin
                dec.op = {2'b0, insn[9:8]};
                dec.rd = {insn[7], insn[2:0]};
                dec.rb = insn[6:3];
            end
            CLS_LIT_LOAD, CLS_MEM_SP, CLS_ADDR_GEN: begin
                dec.op  = {3'b0, insn[11]};
                dec.rd  = {1'b0, insn[10:8]};
                dec.imm = zext11(11'(insn[7:0])) << 2;
            end
            CLS_MEM_REG: begin
                dec.op = {1'b0, insn[11:9]};
                dec.rb = {1'b0, insn[8:6]};
                dec.ra = {1'b0, insn[5:3]};
                dec.rd = {1'b0, insn[2:0]};
            end
            CLS_MEM_WORD, CLS_MEM_BYTE, CLS_MEM_HALF: begin
                dec.op = {3'b0, insn[11]};
                dec.ra = {1'b0, insn[5:3]};
                dec.rd = {1'b0, insn[2:0]};
                if (cls == CLS_MEM_WORD)
                    dec.imm = zext11(11'(amt5)) << 2;
                else if (cls == CLS_MEM_HALF)
                    dec.imm = zext11(11'(amt5)) << 1;
                else
                    dec.imm = zext11(11'(amt5));
            end
            CLS_SP_ADJ: begin
                dec.op  = {3'b0, insn[7]};
                dec.imm = zext11(11'(insn[6:0])) << 2;
            end
            CLS_PUSH_POP: begin
                dec.op    = {2'b0, insn[8], insn[11]};
                dec.rlist = insn[7:0];
            end
            CLS_BLOCK: begin
                dec.op    = {3'b0, insn[11]};
                dec.ra    = {1'b0, insn[10:8]};
                dec.rlist = insn[7:0];
            end
            CLS_TRAP: begin
                dec.imm = zext11(11'(insn[7:0]));
            end
            CLS_BCOND: begin
                dec.op  = insn[11:8];
                dec.imm = sext8(insn[7:0]) << 1;
            end
            CLS_BSHORT: begin
                dec.imm = sext11(insn[10:0]) << 1;
            end
            CLS_BL_HI: begin
                dec.imm = sext11(insn[10:0]) << 12;
            end
            CLS_BL_LO: begin
                dec.imm = zext11(insn[10:0]) << 1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cinsn_class_dec.sv
`timescale 1ns/1ps
module cinsn_class_dec
    import cid_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           valid_i,
    input  logic [IW-1:0]  insn_i,
    output logic           valid_o,
    output logic           undef_o,
    output logic [CW-1:0]  cls_o,
    output logic [RW-1:0]  rd_o,
    output logic [RW-1:0]  ra_o,
    output logic [RW-1:0]  rb_o,
    output logic [OPW-1:0] op_o,
    output logic [LW-1:0]  rlist_o,
    output logic [XW-1:0]  imm_o
);
    typedef struct packed {
        logic vld;
        dec_t dec;
    } stage_t;

    cls_e   cls_w;
    dec_t   dec_w;
    stage_t stage_d;
    stage_t stage_q;

    cid_match  u_match  (.insn(insn_i), .cls(cls_w));
    cid_fields u_fields (.insn(insn_i), .cls(cls_w), .dec(dec_w));

    always_comb begin
        stage_d.vld = valid_i;
        stage_d.dec = dec_w;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q <= '0;
                else         stage_q <= stage_d;
            end
        end else begin : g_comb
            always_comb stage_q = stage_d;
        end
    endgenerate

    assign valid_o = stage_q.vld;
    assign undef_o = stage_q.dec.undef;
    assign cls_o   = stage_q.dec.cls;
    assign rd_o    = stage_q.dec.rd;
    assign ra_o    = stage_q.dec.ra;
    assign rb_o    = stage_q.dec.rb;
    assign op_o    = stage_q.dec.op;
    assign rlist_o = stage_q.dec.rlist;
    assign imm_o   = stage_q.dec.imm;

    // Priority order between overlapping classes
    assert_addsub_over_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_i[15:11] == 5'b00011) |->
            (dec_w.cls == CLS_ADDSUB_REG || dec_w.cls == CLS_ADDSUB_IMM));
    assert_bx_over_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_i[15:7] == 9'b010001110) |-> (dec_w.cls == CLS_BX));
    assert_trap_over_bcond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_i[15:8] == 8'hDF) |-> (dec_w.cls == CLS_TRAP));
    // Undefined halfwords carry no field content
    assert_undef_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_w.undef |-> (dec_w.imm == '0 && dec_w.rd == '0 && dec_w.ra == '0 &&
                         dec_w.rb == '0 && dec_w.op == '0 && dec_w.rlist == '0));
    // Shift amount for the right-shift forms is never zero
    assert_shift_amount_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_w.cls == CLS_SHIFT_IMM && insn_i[12:11] != 2'b00) |->
            (dec_w.imm >= XW'(1) && dec_w.imm <= XW'(32)));
endmodule

// File: tb/sim_cinsn_class_dec.sv
`timescale 1ns/1ps
module sim_cinsn_class_dec;
    import cid_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] insn = '0;
    logic        valid_o, undef_o;
    logic [4:0]  cls_o;
    logic [3:0]  rd_o, ra_o, rb_o, op_o;
    logic [7:0]  rlist_o;
    logic [31:0] imm_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        dec_t  exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    cinsn_class_dec u0 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .insn_i(insn),
        .valid_o(valid_o), .undef_o(undef_o), .cls_o(cls_o), .rd_o(rd_o),
        .ra_o(ra_o), .rb_o(rb_o), .op_o(op_o), .rlist_o(rlist_o), .imm_o(imm_o)
    );

    // Independent reference model written from the requirements
    function automatic dec_t ref_dec(input logic [15:0] h);
        dec_t r;
        int   c;
        r = '0;
        c = 0;
        if (h[15:11] == 5'b00011) begin                      // R2
            c = h[10] ? 2 : 1;
            r.op = {3'b0, h[9]}; r.ra = {1'b0, h[5:3]}; r.rd = {1'b0, h[2:0]};
            if (h[10]) r.imm = {29'b0, h[8:6]};
            else       r.rb  = {1'b0, h[8:6]};
        end else if (h[15:13] == 3'b000) begin               // R6
            c = 3;
            r.op = {2'b0, h[12:11]}; r.ra = {1'b0, h[5:3]}; r.rd = {1'b0, h[2:0]};
            r.imm = {27'b0, h[10:6]};
            if (h[10:6] == 5'd0 && h[12:11] != 2'd0) r.imm = 32'd32;
        end else if (h[15:13] == 3'b001) begin
            c = 4; r.op = {2'b0, h[12:11]}; r.rd = {1'b0, h[10:8]}; r.imm = {24'b0, h[7:0]};
        end else if (h[15:10] == 6'b010000) begin
            c = 5; r.op = h[9:6]; r.rb = {1'b0, h[5:3]}; r.rd = {1'b0, h[2:0]};
        end else if (h[15:7] == 9'b010001110) begin          // R3
            c = 6; r.rb = h[6:3];
        end else if (h[15:10] == 6'b010001) begin            // R5
            c = 7; r.op = {2'b0, h[9:8]}; r.rd = {h[7], h[2:0]}; r.rb = h[6:3];
        end else if (h[15:11] == 5'b01001) begin
            c = 8; r.op = {3'b0, h[11]}; r.rd = {1'b0, h[10:8]}; r.imm = {22'b0, h[7:0], 2'b0};
        end else if (h[15:12] == 4'b0101) begin              // R11
            c = 9; r.op = {1'b0, h[11:9]}; r.rb = {1'b0, h[8:6]};
            r.ra = {1'b0, h[5:3]}; r.rd = {1'b0, h[2:0]};
        end else if (h[15:12] inside {4'b0110, 4'b0111, 4'b1000}) begin
            r.op = {3'b0, h[11]}; r.ra = {1'b0, h[5:3]}; r.rd = {1'b0, h[2:0]};
            if (h[15:12] == 4'b0110)      begin c = 10; r.imm = {25'b0, h[10:6], 2'b0}; end
            else if (h[15:12] == 4'b0111) begin c = 11; r.imm = {27'b0, h[10:6]}; end
            else                          begin c = 12; r.imm = {26'b0, h[10:6], 1'b0}; end
        end else if (h[15:13] == 3'b100 || h[15:12] == 4'b1010) begin
            c = h[13] ? 14 : 13;
            r.op = {3'b0, h[11]}; r.rd = {1'b0, h[10:8]}; r.imm = {22'b0, h[7:0], 2'b0};
        end else if (h[15:8] == 8'hB0) begin                 // R9
            c = 15; r.op = {3'b0, h[7]}; r.imm = {23'b0, h[6:0], 2'b0};
        end else if (h[15:12] == 4'hB && h[10:9] == 2'b10) begin
            c = 16; r.op = {2'b0, h[8], h[11]}; r.rlist = h[7:0];
        end else if (h[15:12] == 4'hC) begin
            c = 17; r.op = {3'b0, h[11]}; r.ra = {1'b0, h[10:8]}; r.rlist = h[7:0];
        end else if (h[15:8] == 8'hDF) begin                 // R4
            c = 18; r.imm = {24'b0, h[7:0]};
        end else if (h[15:12] == 4'hD) begin                 // R7
            c = 19; r.op = h[11:8]; r.imm = {{23{h[7]}}, h[7:0], 1'b0};
        end else if (h[15:11] == 5'b11100) begin
            c = 20; r.imm = {{20{h[10]}}, h[10:0], 1'b0};
        end else if (h[15:11] == 5'b11110) begin             // R8
            c = 21; r.imm = {{9{h[10]}}, h[10:0], 12'b0};
        end else if (h[15:11] == 5'b11111) begin
            c = 22; r.imm = {20'b0, h[10:0], 1'b0};
        end
        r.cls   = cls_e'(c[4:0]);
        r.undef = (c == 0);                                   // R1
        return r;
    endfunction

    function automatic string tag_of(input cls_e c);
        case (c)
            CLS_UNDEF:                                 return "R1";
            CLS_ADDSUB_REG, CLS_ADDSUB_IMM:            return "R2";
            CLS_BX:                                    return "R3";
            CLS_TRAP:                                  return "R4";
            CLS_ALU_HI:                                return "R5";
            CLS_SHIFT_IMM:                             return "R6";
            CLS_BCOND, CLS_BSHORT:                     return "R7";
            CLS_BL_HI, CLS_BL_LO:                      return "R8";
            CLS_SP_ADJ, CLS_PUSH_POP:                  return "R9";
            CLS_MEM_REG:                               return "R11";
            CLS_IMM8, CLS_ALU, CLS_BLOCK:              return "R13";
            default:                                   return "R10";
        endcase
    endfunction

    task automatic send(input logic [15:0] h, input string tag);
        item_t it;
        @(negedge clk);
        insn = h;
        vld  = 1'b1;
        it.exp = ref_dec(h);
        it.tag = (tag == "") ? tag_of(it.exp.cls) : tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vld  = 1'b0;
            insn = 16'hFFFF;
        end
    endtask

    // Monitor: compares each valid result against the front of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid_o) begin
                dec_t  got;
                item_t it;
                got.undef = undef_o; got.cls = cls_e'(cls_o); got.rd = rd_o;
                got.ra = ra_o; got.rb = rb_o; got.op = op_o; got.rlist = rlist_o;
                got.imm = imm_o;
                checks++;
                if (sb.size() == 0) begin
                    failures++;
                    $display("FAIL R12 result without input: got %h expected none", got);
                end else begin
                    it = sb.pop_front();
                    if (got !== it.exp) begin
                        failures++;
                        $display("FAIL %s got %h expected %h", it.tag, got, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #950000;
        failures++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        vld = 1'b1; insn = 16'h1800;
        @(negedge clk);
        checks++;                                            // R12 reset state
        if (valid_o !== 1'b0 || cls_o !== 5'd0 || imm_o !== 32'd0 || undef_o !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset state got v=%b c=%0d i=%h expected 0", valid_o, cls_o, imm_o);
        end
        vld = 1'b0;
        rst_n = 1'b1;

        send(16'h1A53, "R2");  send(16'h1E9D, "R2");  send(16'h1FFF, "R2");
        send(16'h47B8, "R3");  send(16'h4778, "R3");  send(16'h47F8, "R5");
        send(16'hDF7E, "R4");  send(16'hDE80, "R7");  send(16'hD0FF, "R7");
        send(16'h46BF, "R5");  send(16'h4587, "R5");
        send(16'h0800, "R6");  send(16'h1000, "R6");  send(16'h0000, "R6");  send(16'h07C9, "R6");
        send(16'hE400, "R7");  send(16'hE3FF, "R7");
        send(16'hF400, "R8");  send(16'hF7FF, "R8");  send(16'hFFFF, "R8");
        send(16'hB0FF, "R9");  send(16'hB07F, "R9");  send(16'hBDA5, "R9");  send(16'hB501, "R9");
        send(16'hB100, "R1");  send(16'hB800, "R1");  send(16'hB200, "R1");  send(16'hE800, "R1");
        send(16'h68CA, "R10"); send(16'h7FFF, "R10"); send(16'h8FC0, "R10");
        send(16'h9AFF, "R10"); send(16'hA9C3, "R10"); send(16'h4DFF, "R10");
        send(16'h5FFF, "R11"); send(16'h5252, "R11");
        send(16'h2BA5, "R13"); send(16'h43F1, "R13"); send(16'hCB81, "R13");
        idle(2);
        send(16'hDF01, "R12");
        idle(3);
        send(16'hE001, "R12");

        for (int i = 0; i < 65536; i++) send(16'(i), "");
        idle(4);

        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R12 missing results: got %0d pending expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule